// File: doc/BRIEF.md
# Banked Operand Fetch Stall Unit

This block sits at the operand-read step of a SIMT-style pipeline and models only its timing. An instruction arrives with up to three source register specifiers, each a register index plus a two-bit kind field. The register file behind the stage is split into four banks, selected by the low two bits of the index. Two sources that need a read from the same bank cannot be served together. Each such pair costs one extra cycle.

After an instruction is taken in, the stage holds it for two cycles plus its conflict count. It then offers the instruction downstream on a valid/ready handshake, together with the number of conflicts it found. A running total of all stall cycles is kept beside the datapath and saturates instead of wrapping. Only one instruction is inside the stage at a time, so the input side is not ready while an instruction is waiting or being offered.

Top module: `operand_stall_stage`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid` is 0 and `stall_total` is 0.
- R2: A source's bank is bits [1:0] of its index. Every unordered pair of live sources in the same bank adds exactly one to the conflict count, which is reported on `out_conflicts` while `out_valid` is high.
- R3: A slot whose kind field is 2'b00 (unused; 2'b01 and 2'b10 both mean a real read) never joins a conflicting pair.
- R4: A source whose index is 0 never joins a conflicting pair.
- R5: If an instruction is accepted on clock edge E with conflict count n, `out_valid` first reads 1 after edge E+2+n and stays 0 before that.
- R6: An instruction is accepted only on an edge where `in_valid` and `in_ready` are both 1. `in_ready` is 0 from the edge after an accept until the edge on which the output handshake completes.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_tag` and `out_conflicts` hold their values. The instruction leaves on the first edge where `out_ready` is 1.
- R8: On the edge an instruction is accepted, `stall_total` grows by its conflict count.
- R9: When the sum would pass the all-ones value of `stall_total`, the counter stays at all ones and does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An instruction is offered |
| in_ready | output | 1 | The stage is empty and can take an instruction |
| in_idx | input | NUM_SRC*IDX_W | Source register indices, slot k at bits [k*IDX_W +: IDX_W] |
| in_kind | input | NUM_SRC*2 | Source kinds, slot k at bits [2k +: 2]; 00 unused, 01 integer, 10 float |
| in_tag | input | TAG_W | Opaque instruction payload carried through |
| out_valid | output | 1 | The instruction has finished its latency and is offered |
| out_ready | input | 1 | Downstream takes the offered instruction |
| out_tag | output | TAG_W | Payload of the offered instruction |
| out_conflicts | output | CONF_W | Bank-conflict count of the offered instruction |
| stall_total | output | CNT_W | Saturating sum of all conflict counts |

## Verification
The saturation of the stall total and an ordinary accumulation can land on the same accept edge. This happens when the counter sits a few counts below its ceiling and an instruction with more conflicts than the remaining headroom arrives. The bench builds the stage with a narrow counter and sends a burst of three-way conflicts. The total steps up by three until one accept would overshoot; on that edge it must clamp to all ones and then stay there. Output backpressure and gaps on the input run at the same time, so the latency countdown, the hold of the offered instruction and the counter update are all compared against a behavioural model on every cycle.

// File: rtl/operand_stall_stage.sv
module operand_stall_stage #(
  parameter int NUM_SRC   = 3,
  parameter int IDX_W     = 5,
  parameter int BANK_BITS = 2,
  parameter int TAG_W     = 8,
  parameter int CNT_W     = 32,
  localparam int NPAIR    = NUM_SRC * (NUM_SRC - 1) / 2,
  localparam int CONF_W   = $clog2(NPAIR + 1),
  localparam int LAT_W    = $clog2(NPAIR + 3)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [NUM_SRC*IDX_W-1:0] in_idx,
  input  logic [NUM_SRC*2-1:0]     in_kind,
  input  logic [TAG_W-1:0]         in_tag,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [TAG_W-1:0]         out_tag,
  output logic [CONF_W-1:0]        out_conflicts,
  output logic [CNT_W-1:0]         stall_total
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [NUM_SRC-1:0] live;
  logic [NPAIR-1:0]   pair_hit;
  logic [CONF_W-1:0]  n_conf;
  logic               busy;
  logic [LAT_W-1:0]   wait_cnt;
  logic [CNT_W:0]     sum_wide;
  logic               take, give;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_live
    assign live[i] = (in_kind[2*i +: 2] != 2'b00) && (in_idx[IDX_W*i +: IDX_W] != '0);
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_row
    for (genvar j = i + 1; j < NUM_SRC; j++) begin : g_col
      localparam int P = i * NUM_SRC - (i * (i + 1)) / 2 + (j - i - 1);
      assign pair_hit[P] = live[i] && live[j] &&
        (in_idx[IDX_W*i +: BANK_BITS] == in_idx[IDX_W*j +: BANK_BITS]);
    end
  end

  always_comb begin
    n_conf = '0;
    for (int k = 0; k < NPAIR; k++) n_conf = n_conf + CONF_W'(pair_hit[k]);
  end

  assign in_ready  = !busy;
  assign out_valid = busy && (wait_cnt == '0);
  assign take      = in_valid && in_ready;
  assign give      = out_valid && out_ready;
  assign sum_wide  = {1'b0, stall_total} + (CNT_W+1)'(n_conf);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy          <= 1'b0;
      wait_cnt      <= '0;
      out_tag       <= '0;
      out_conflicts <= '0;
      stall_total   <= '0;
    end else begin
      if (take) begin
        busy          <= 1'b1;
        wait_cnt      <= LAT_W'(n_conf) + LAT_W'(2);
        out_tag       <= in_tag;
        out_conflicts <= n_conf;
        stall_total   <= sum_wide[CNT_W] ? CNT_MAX : sum_wide[CNT_W-1:0];
      end else if (busy && wait_cnt != '0) begin
        wait_cnt <= wait_cnt - 1'b1;
      end else if (give) begin
        busy <= 1'b0;
      end
    end
  end

  a_r6_single_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  a_r5_no_early_output: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !out_valid);

  a_r7_hold_offer: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_tag) && $stable(out_conflicts)));

  a_r8_total_monotone: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |=> $stable(stall_total));

  a_r9_stays_saturated: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_total == CNT_MAX) |=> (stall_total == CNT_MAX));

  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (int'(out_conflicts) <= NPAIR));

endmodule

// File: tb/operand_stall_stage_test.sv
module operand_stall_stage_test;
  localparam int NS = 3, IW = 5, TW = 8, CW = 6;
  localparam int MAXV = (1 << CW) - 1;
  localparam int ND = 29;

  logic clk = 0, rst_n = 0, in_valid = 0, out_ready = 0;
  logic [NS*IW-1:0] in_idx = '0;
  logic [NS*2-1:0]  in_kind = '0;
  logic [TW-1:0]    in_tag = '0;
  logic             in_ready, out_valid;
  logic [TW-1:0]    out_tag;
  logic [1:0]       out_conflicts;
  logic [CW-1:0]    stall_total;

  operand_stall_stage #(.NUM_SRC(NS), .IDX_W(IW), .BANK_BITS(2), .TAG_W(TW), .CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_idx(in_idx), .in_kind(in_kind), .in_tag(in_tag),
    .out_valid(out_valid), .out_ready(out_ready), .out_tag(out_tag),
    .out_conflicts(out_conflicts), .stall_total(stall_total));

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;

  int m_wait = -1, m_conf = 0, m_total = 0, m_tag = 0;
  string m_req = "R2";

  logic [NS*IW-1:0] d_idx [ND];
  logic [NS*2-1:0]  d_kind[ND];
  string            d_req [ND];
  int dp = 0;

  function automatic int conf_of(logic [NS*IW-1:0] ix, logic [NS*2-1:0] kd);
    int n = 0;
    for (int i = 0; i < NS; i++)
      for (int j = i + 1; j < NS; j++)
        if (kd[2*i +: 2] != 0 && kd[2*j +: 2] != 0 &&
            ix[IW*i +: IW] != 0 && ix[IW*j +: IW] != 0 &&
            (ix[IW*i +: IW] % 4) == (ix[IW*j +: IW] % 4)) n++;
    return n;
  endfunction

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic logic [NS*IW-1:0] pk(int a, int b, int c);
    return {IW'(c), IW'(b), IW'(a)};
  endfunction

  initial begin
    d_idx[0] = pk(4, 8, 12);  d_kind[0] = 6'b10_01_01; d_req[0] = "R2";
    d_idx[1] = pk(1, 5, 2);   d_kind[1] = 6'b01_01_01; d_req[1] = "R2";
    d_idx[2] = pk(0, 4, 8);   d_kind[2] = 6'b01_01_01; d_req[2] = "R4";
    d_idx[3] = pk(0, 0, 0);   d_kind[3] = 6'b01_01_01; d_req[3] = "R4";
    d_idx[4] = pk(4, 8, 12);  d_kind[4] = 6'b01_00_01; d_req[4] = "R3";
    d_idx[5] = pk(4, 8, 12);  d_kind[5] = 6'b00_00_00; d_req[5] = "R3";
    d_idx[6] = pk(3, 7, 9);   d_kind[6] = 6'b10_10_10; d_req[6] = "R2";
    for (int k = 7; k < ND; k++) begin
      d_idx[k] = pk(4, 8, 12); d_kind[k] = 6'b01_01_01; d_req[k] = "R9";
    end
  end

  initial begin
    #(20 * 5000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    for (int cyc = 0; cyc < 1500; cyc++) begin
      @(negedge clk);
      if (cyc == 0) begin
        rst_n = 1;
        check("R1", "in_ready", int'(in_ready), 1);
        check("R1", "out_valid", int'(out_valid), 0);
        check("R1", "stall_total", int'(stall_total), 0);
      end else begin
        check("R6", "in_ready", int'(in_ready), (m_wait < 0) ? 1 : 0);
        check("R5", "out_valid", int'(out_valid), (m_wait == 0) ? 1 : 0);
        check((m_total == MAXV) ? "R9" : "R8", "stall_total", int'(stall_total), m_total);
        if (m_wait == 0) begin
          check("R7", "out_tag", int'(out_tag), m_tag);
          check(m_req, "out_conflicts", int'(out_conflicts), m_conf);
        end
      end
      // drive next inputs
      if (dp < ND) begin
        in_valid = ($urandom_range(0, 3) != 0);
        in_idx = d_idx[dp];
        in_kind = d_kind[dp];
      end else begin
        in_valid = ($urandom_range(0, 2) != 0);
        for (int s = 0; s < NS; s++) begin
          in_idx[IW*s +: IW] = ($urandom_range(0, 1) != 0) ? IW'($urandom_range(0, 3) * 4)
                                                           : IW'($urandom_range(0, 31));
          in_kind[2*s +: 2] = 2'($urandom_range(0, 2));
        end
      end
      in_tag = TW'($urandom_range(0, 255));
      out_ready = ($urandom_range(0, 9) < 6);
      // model step at next rising edge
      if (m_wait < 0) begin
        if (in_valid) begin
          m_conf = conf_of(in_idx, in_kind);
          m_wait = 2 + m_conf;
          m_tag = int'(in_tag);
          m_total = (m_total + m_conf > MAXV) ? MAXV : m_total + m_conf;
          m_req = (dp < ND) ? d_req[dp] : "R2";
          if (dp < ND) dp++;
        end
      end else if (m_wait > 0) begin
        m_wait--;
      end else if (out_ready) begin
        m_wait = -1;
      end
    end
    check("R9", "saturated_total", int'(stall_total), MAXV);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule